// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds the return addresses of a small processor core. It has eight slots of thirteen bits each and sits outside both the program memory and the data memory. When the core enters a subroutine or takes an interrupt vector, it pulses `push_i` with the address to come back to. When it executes any of its return-type instructions (plain return, return carrying a literal, return from interrupt), it pulses `pop_i` and takes the address from `top_o` in that same cycle. The logic that decides when to push or pop belongs to the core.

The stack pointer is internal. Software cannot read or write it, and there is no overflow or underflow flag. The slots form a ring. Once all eight are full, each further push overwrites the oldest entry. A pop on an empty stack steps the pointer backwards around the ring and returns whatever that slot holds. Reset moves the pointer to slot zero and leaves the stored addresses as they are.

Both strobes are plain control pins with no handshake. The stack accepts an operation in every cycle and never applies back-pressure, so no ready signal exists. The core must never raise `push_i` and `pop_i` in the same cycle.

Top module: `ret_addr_stack`

## Requirements
- R1: In the cycle after a push, `top_o` equals the address that was pushed.
- R2: During a pop cycle, `top_o` is the most recently pushed entry still on the stack. In the cycle after the pop, `top_o` shows the entry that was pushed before it. `push_i` and `pop_i` are never high together.
- R3: After eight pushes, eight pops return the pushed addresses in reverse order.
- R4: The pointer advances by one per push, modulo 8. A ninth push overwrites the first entry and a tenth overwrites the second. After ten pushes of v0..v9, ten pops return v9, v8, ..., v2 and then v9, v8.
- R5: A pop with the pointer at slot zero wraps the pointer to slot seven. That pop returns the contents of slot seven, and the next pop returns slot six.
- R6: Reset (synchronous, active high) sets the pointer to slot zero and keeps the slot contents. After reset, `top_o` shows slot seven, and the next push writes slot zero.
- R7: In a cycle with neither push nor pop, `top_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset of the pointer only |
| push_i | input | 1 | Store `push_addr_i` and advance the pointer |
| push_addr_i | input | 13 | Return address to store |
| pop_i | input | 1 | Move the pointer back one slot |
| top_o | output | 13 | Entry just below the pointer; the return address during a pop |

## Verification
The assertions assume that `push_i` and `pop_i` are never high together. Checks on the value of `top_o` also assume that every slot has been written at least once since power-up, because reset does not clear the slots. The checker therefore keeps its own record of the slots that have been written and guards the data properties with it. The stimulus holds one strobe at a time. It fills all eight slots before it pops anything, and it pops from an empty stack only after the slots hold known values, so the wrap-around cases compare against defined data.

// File: rtl/ret_addr_stack_pkg.sv
package ret_addr_stack_pkg;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/ret_addr_stack_ptr.sv
module ret_addr_stack_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = ret_addr_stack_pkg::ptr_bits(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [PW-1:0] sp_o,
  output logic [PW-1:0] below_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] sp_q;
  logic [PW-1:0] sp_inc;
  logic [PW-1:0] sp_dec;

  // explicit wrap so that a depth other than a power of two still forms a ring
  always_comb begin
    sp_inc = (sp_q == LAST) ? '0 : sp_q + 1'b1;
    sp_dec = (sp_q == '0) ? LAST : sp_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sp_q <= '0;
    end else if (push_i) begin
      sp_q <= sp_inc;
    end else if (pop_i) begin
      sp_q <= sp_dec;
    end
  end

  assign sp_o    = sp_q;
  assign below_o = sp_dec;
endmodule

// File: rtl/ret_addr_stack_slots.sv
module ret_addr_stack_slots #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 13,
  localparam int unsigned PW = ret_addr_stack_pkg::ptr_bits(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      wr_en_i,
  input  logic [PW-1:0]             wr_idx_i,
  input  logic [AW-1:0]             wr_data_i,
  output logic [DEPTH-1:0][AW-1:0]  slots_o
);
  // slots carry no reset: contents survive a pointer reset
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [AW-1:0] slot_q;
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_idx_i == PW'(s))) begin
        slot_q <= wr_data_i;
      end
    end
    assign slots_o[s] = slot_q;
  end
endmodule

// File: rtl/ret_addr_stack_rdsel.sv
module ret_addr_stack_rdsel #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 13,
  localparam int unsigned PW = ret_addr_stack_pkg::ptr_bits(DEPTH)
) (
  input  logic [DEPTH-1:0][AW-1:0] slots_i,
  input  logic [PW-1:0]            idx_i,
  output logic [AW-1:0]            data_o
);
  always_comb begin
    data_o = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (idx_i == PW'(s)) data_o = slots_i[s];
    end
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 13
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [AW-1:0] top_o
);
  localparam int unsigned PW = ret_addr_stack_pkg::ptr_bits(DEPTH);

  logic [PW-1:0]            sp_q;
  logic [PW-1:0]            below;
  logic [DEPTH-1:0][AW-1:0] slots;

  ret_addr_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .sp_o    (sp_q),
    .below_o (below)
  );

  ret_addr_stack_slots #(.DEPTH(DEPTH), .AW(AW)) u_slots (
    .clk_i     (clk_i),
    .wr_en_i   (push_i),
    .wr_idx_i  (sp_q),
    .wr_data_i (push_addr_i),
    .slots_o   (slots)
  );

  ret_addr_stack_rdsel #(.DEPTH(DEPTH), .AW(AW)) u_rdsel (
    .slots_i (slots),
    .idx_i   (below),
    .data_o  (top_o)
  );
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 13,
  localparam int unsigned PW = ret_addr_stack_pkg::ptr_bits(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          push_i,
  input logic [AW-1:0] push_addr_i,
  input logic          pop_i,
  input logic [AW-1:0] top_o,
  input logic [PW-1:0] sp_i
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DEPTH-1:0] written = '0;
  logic [1:0]       cyc     = '0;
  logic             rst_d   = 1'b0;
  logic             all_def;

  assign all_def = &written;

  always_ff @(posedge clk_i) begin
    if (push_i && !rst_i) written[sp_i] <= 1'b1;
    if (rst_i) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    rst_d <= rst_i;
  end

  // R6: one cycle after reset was applied the pointer sits at slot zero
  always_ff @(posedge clk_i) begin
    if (rst_d) begin
      a_reset_ptr_r6: assert (sp_i == '0);
    end
  end

  p_single_op_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !(push_i && pop_i));

  p_push_top_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    push_i |=> (top_o == $past(push_addr_i)));

  p_pop_restore_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc >= 2'd2 && all_def && pop_i && $past(push_i)) |=> (top_o == $past(top_o, 2)));

  p_ptr_inc_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    push_i |=> (sp_i == (($past(sp_i) == LAST) ? '0 : $past(sp_i) + 1'b1)));

  p_ptr_dec_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (pop_i && !push_i) |=> (sp_i == (($past(sp_i) == '0) ? LAST : $past(sp_i) - 1'b1)));

  p_idle_stable_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (all_def && !push_i && !pop_i) |=> $stable(top_o));

  // R3 follows from R1, R2 and R4 together; the bench checks the full order
endmodule

bind ret_addr_stack ret_addr_stack_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .push_i      (push_i),
  .push_addr_i (push_addr_i),
  .pop_i       (pop_i),
  .top_o       (top_o),
  .sp_i        (sp_q)
);

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;
  localparam int DEPTH = 8;
  localparam int AW    = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst  = 1'b1;
  logic          push = 1'b0;
  logic          pop  = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] top;

  ret_addr_stack #(.DEPTH(DEPTH), .AW(AW)) i_ret_addr_stack (
    .clk_i (clk), .rst_i (rst), .push_i (push),
    .push_addr_i (addr), .pop_i (pop), .top_o (top)
  );

  logic [AW-1:0] mdl [DEPTH];
  int            mptr;
  int            n_vec = 0;
  int            n_bad = 0;
  logic [AW-1:0] exp_q [$];
  string         tag_q [$];

  function automatic int prev(input int p);
    return (p + DEPTH - 1) % DEPTH;
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: top_o=%h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end 1 ns after a rising edge
  task automatic do_push(input logic [AW-1:0] v, input string tag);
    push = 1'b1; addr = v;
    mdl[mptr] = v; mptr = (mptr + 1) % DEPTH;
    @(posedge clk); #1;
    push = 1'b0;
    check(top, v, tag);
  endtask

  task automatic do_pop(input string tag);
    pop = 1'b1;
    exp_q.push_back(mdl[prev(mptr)]);
    tag_q.push_back(tag);
    mptr = prev(mptr);
    @(posedge clk); #1;
    pop = 1'b0;
  endtask

  // monitor: compares every popped value against the scoreboard
  always @(negedge clk) begin
    if (pop && !rst) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R2: pop seen top_o=%h expected no pop", top);
      end else begin
        check(top, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1..: watchdog expired, actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [AW-1:0] hold;
    logic [15:0]   lfsr;
    mptr = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: fill all slots
    for (int i = 0; i < DEPTH; i++) do_push(AW'(13'h100 + i * 37), "R1");
    // R3: reverse order
    for (int i = 0; i < DEPTH; i++) do_pop("R3");

    // R2: push then pop restores the previous top
    hold = top;
    do_push(13'h0ABC, "R1");
    do_pop("R2");
    check(top, hold, "R2");

    // R4: ten pushes, ten pops
    for (int i = 0; i < 10; i++) do_push(AW'(13'h1A00 + i), "R1");
    for (int i = 0; i < 10; i++) do_pop("R4");

    // R7: idle cycles hold top
    hold = top;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      check(top, hold, "R7");
    end

    // R6: reset keeps contents, pointer to zero
    do_push(13'h0111, "R1");
    do_push(13'h0222, "R1");
    do_push(13'h0333, "R1");
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    mptr = 0;
    check(top, mdl[DEPTH-1], "R6");

    // R5: pop on empty wraps backwards
    do_pop("R5");
    do_pop("R5");
    check(top, mdl[DEPTH-3], "R5");

    // R6: next push after reset lands in slot 0 (visible after pointer returns)
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    mptr = 0;
    do_push(13'h1555, "R6");
    do_pop("R6");
    do_pop("R5");

    // mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) do_push(AW'(lfsr[15:3]), "R1");
      else if (lfsr[1]) do_pop("R3");
      else begin
        hold = top;
        @(posedge clk); #1;
        check(top, hold, "R7");
      end
    end

    @(posedge clk); #1;
    finish_run();
  end
endmodule